// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit gathers the event indications of an I2C controller core into one status word, qualifies that word with a programmable enable mask, and drives a single interrupt request to the processor. Software reads the masked view to see which events need service. It acknowledges each event by reading a clear address that belongs to that event alone, or it acknowledges all of them at once through a common clear address.

Two of the twelve status positions are not stored in the unit. They follow the FIFO threshold comparators of the core directly. When the core aborts a transmission, the unit keeps the reasons in a cause register. In the cycle after the abort it also issues a one-cycle request that empties both FIFOs. The cause register is wiped by the same read that acknowledges the abort flag.

Top module: `i2c_irq_unit`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[k]` sets status bit k, for k in {0,1,3,5,6,7,8,9,10,11}. The bit is visible in the raw status (offset 0x34) from the clock edge that samples the pulse and stays set until it is cleared. Bit meanings: 0 RX underflow, 1 RX overflow, 3 TX overflow, 5 read request, 6 TX abort, 7 RX done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R2: Status bit 2 equals `rx_full_lvl` and status bit 4 equals `tx_empty_lvl`, combinationally. No read of any clear address changes them, and the pulses `evt_pulse[2]` and `evt_pulse[4]` have no effect.
- R3: The mask register (offset 0x30, bits 11:0) resets to 0xFFF and is loaded by a bus write to 0x30. A read of 0x2C returns raw status ANDed with the mask.
- R4: `irq` is high exactly when at least one bit of the masked status is set.
- R5: A read of a per-source clear address clears only that source's bit. The addresses are 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10 and 0x68 bit 11.
- R6: A read of 0x40 clears every latched status bit and also zeroes the abort-cause register.
- R7: If an event pulse arrives in the same cycle as a clearing read for its bit, the bit is set after that edge.
- R8: Each pulse on `evt_pulse[6]` ORs `abort_why` into the abort-cause register (offset 0x80). Only the defined positions are kept: 0 7-bit address no-ack, 1 and 2 first and second 10-bit address byte no-ack, 3 data no-ack, 4 general-call no-ack, 5 read after general call, 7 start byte acked, 9 start byte without restart, 10 10-bit read without restart, 11 master disabled, 12 arbitration lost. All other bits read zero.
- R9: A read of 0x54 zeroes the abort-cause register together with status bit 6.
- R10: `fifo_flush` is high for exactly the one cycle that follows each cycle in which `evt_pulse[6]` is high.
- R11: After reset, raw status (apart from bits 2 and 4), abort cause, `irq` and `fifo_flush` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 12 | Event pulses from the core, one per status position |
| rx_full_lvl | input | 1 | Receive FIFO at or above threshold |
| tx_empty_lvl | input | 1 | Transmit FIFO at or below threshold |
| abort_why | input | 13 | Abort reasons, valid with evt_pulse[6] |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 12 | Write data for the mask |
| bus_rdata | output | 16 | Read data, combinational from address and state |
| irq | output | 1 | Interrupt request |
| fifo_flush | output | 1 | One-cycle request to empty both FIFOs |

## Verification
Read data, the two level bits and `irq` are combinational. The bench therefore samples them a few nanoseconds after it drives the inputs, before the next rising edge. Latched bits, the cause register and mask writes take effect at the rising edge that samples the request, so they are checked with a read started in the following cycle. The effect of a clearing read is likewise checked by a second read after that edge. `fifo_flush` is due one edge after the abort pulse: the bench samples it just after that edge and checks again after the next edge that it has fallen.

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int NSRC    = 12,
  parameter int CAUSE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_pulse,
  input  logic              rx_full_lvl,
  input  logic              tx_empty_lvl,
  input  logic [CAUSE_W-1:0] abort_why,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              fifo_flush
);
  localparam logic [NSRC-1:0]    LEVEL_BITS  = NSRC'(12'h014);
  localparam logic [NSRC-1:0]    LATCH_BITS  = ~LEVEL_BITS;
  localparam logic [CAUSE_W-1:0] CAUSE_VALID = CAUSE_W'(13'h1EBF);
  localparam int                 ABORT_BIT   = 6;

  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_CLALL = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(8'h80);

  logic [NSRC-1:0]    lat_q, mask_q, raw, clr;
  logic [CAUSE_W-1:0] cause_q;
  logic               rd_en;

  assign rd_en = bus_sel & ~bus_wr;
  assign raw   = lat_q | (NSRC'(rx_full_lvl) << 2) | (NSRC'(tx_empty_lvl) << 4);
  assign irq   = |(raw & mask_q);

  always_comb begin
    clr = '0;
    if (rd_en) begin
      case (bus_addr)
        A_CLALL:          clr = LATCH_BITS;
        ADDR_W'(8'h44):   clr[0]  = 1'b1;
        ADDR_W'(8'h48):   clr[1]  = 1'b1;
        ADDR_W'(8'h4C):   clr[3]  = 1'b1;
        ADDR_W'(8'h50):   clr[5]  = 1'b1;
        ADDR_W'(8'h54):   clr[6]  = 1'b1;
        ADDR_W'(8'h58):   clr[7]  = 1'b1;
        ADDR_W'(8'h5C):   clr[8]  = 1'b1;
        ADDR_W'(8'h60):   clr[9]  = 1'b1;
        ADDR_W'(8'h64):   clr[10] = 1'b1;
        ADDR_W'(8'h68):   clr[11] = 1'b1;
        default:          clr = '0;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_MSTAT: bus_rdata = DATA_W'(raw & mask_q);
      A_MASK:  bus_rdata = DATA_W'(mask_q);
      A_RAW:   bus_rdata = DATA_W'(raw);
      A_CAUSE: bus_rdata = DATA_W'(cause_q);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q      <= '0;
      mask_q     <= '1;
      cause_q    <= '0;
      fifo_flush <= 1'b0;
    end else begin
      lat_q      <= ((lat_q & ~clr) | evt_pulse) & LATCH_BITS;
      cause_q    <= (clr[ABORT_BIT] ? '0 : cause_q) |
                    (evt_pulse[ABORT_BIT] ? (abort_why & CAUSE_VALID) : '0);
      fifo_flush <= evt_pulse[ABORT_BIT];
      if (bus_sel && bus_wr && bus_addr == A_MASK)
        mask_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk #(
  parameter int ADDR_W  = 8,
  parameter int NSRC    = 12,
  parameter int CAUSE_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_pulse,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NSRC-1:0]   lat_q,
  input logic [NSRC-1:0]   mask_q,
  input logic [CAUSE_W-1:0] cause_q,
  input logic              fifo_flush
);
  logic rd;
  assign rd = bus_sel & ~bus_wr;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[9] |=> lat_q[9]); // R1
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == ADDR_W'(8'h30)) |=> $stable(mask_q)); // R3
  AST_STOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == ADDR_W'(8'h60) && !evt_pulse[9]) |=> !lat_q[9]); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == ADDR_W'(8'h40) && evt_pulse[1]) |=> lat_q[1]); // R7
  AST_CAUSE_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == ADDR_W'(8'h54) && !evt_pulse[6]) |=> (cause_q == '0)); // R9
  AST_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[6] |=> fifo_flush); // R10
  AST_FLUSH_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(evt_pulse[6])); // R10
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(.ADDR_W(ADDR_W), .NSRC(NSRC), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .lat_q(lat_q), .mask_q(mask_q), .cause_q(cause_q),
  .fifo_flush(fifo_flush)
);

// File: tb/i2c_irq_unit_bench.sv
module i2c_irq_unit_bench;
  logic        clk = 0, rst_n = 0;
  logic [11:0] evt_pulse = '0;
  logic        rx_full_lvl = 0, tx_empty_lvl = 0;
  logic [12:0] abort_why = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [11:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, fifo_flush;
  int errors = 0, checks = 0;

  i2c_irq_unit u_i2c_irq_unit (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0; bus_addr = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [11:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic fire(logic [11:0] e, logic [12:0] why);
    @(negedge clk);
    evt_pulse = e; abort_why = why;
    @(posedge clk); #1 evt_pulse = '0; abort_why = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(8'h34, d); check("R11 raw", d, 16'h0);
    rd(8'h30, d); check("R3 mask reset", d, 16'h0FFF);
    rd(8'h80, d); check("R11 cause", d, 16'h0);
    check("R11 irq", 16'(irq), 16'h0);
    check("R11 flush", 16'(fifo_flush), 16'h0);
  endtask

  task automatic t_latch();
    logic [15:0] d;
    fire(12'h200, '0);
    rd(8'h34, d); check("R1 stop latched", d, 16'h0200);
    check("R4 irq on", 16'(irq), 16'h1);
    rd(8'h60, d);
    rd(8'h34, d); check("R5 stop cleared", d, 16'h0);
    check("R4 irq off", 16'(irq), 16'h0);
    fire(12'h00B, '0);
    rd(8'h34, d); check("R1 bits 0,1,3", d, 16'h000B);
    rd(8'h44, d);
    rd(8'h34, d); check("R5 only bit 0 cleared", d, 16'h000A);
    rd(8'h40, d);
  endtask

  task automatic t_levels();
    logic [15:0] d;
    fire(12'h014, '0);
    rd(8'h34, d); check("R2 pulses on level bits ignored", d, 16'h0);
    rx_full_lvl = 1; tx_empty_lvl = 1;
    rd(8'h34, d); check("R2 levels shown", d, 16'h0014);
    rd(8'h40, d);
    rd(8'h34, d); check("R2 clear all keeps levels", d, 16'h0014);
    rx_full_lvl = 0; tx_empty_lvl = 0;
    rd(8'h34, d); check("R2 levels dropped", d, 16'h0);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(8'h30, 12'h200);
    rd(8'h30, d); check("R3 mask written", d, 16'h0200);
    fire(12'h100, '0);
    rd(8'h2C, d); check("R3 masked hides activity", d, 16'h0);
    check("R4 irq masked off", 16'(irq), 16'h0);
    fire(12'h200, '0);
    rd(8'h2C, d); check("R3 masked shows stop", d, 16'h0200);
    check("R4 irq masked on", 16'(irq), 16'h1);
    rd(8'h34, d); check("R3 raw unaffected by mask", d, 16'h0300);
    rd(8'h40, d);
    rd(8'h34, d); check("R6 clear all", d, 16'h0);
    check("R6 irq off", 16'(irq), 16'h0);
    wr(8'h30, 12'hFFF);
  endtask

  task automatic t_race();
    logic [15:0] d;
    fire(12'h002, '0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h48; evt_pulse = 12'h002;
    @(posedge clk); #1 bus_sel = 0; evt_pulse = '0;
    rd(8'h34, d); check("R7 event beats own clear", d, 16'h0002);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h40; evt_pulse = 12'h800;
    @(posedge clk); #1 bus_sel = 0; evt_pulse = '0;
    rd(8'h34, d); check("R7 event beats clear all", d, 16'h0800);
    rd(8'h40, d);
  endtask

  task automatic t_abort();
    logic [15:0] d;
    fire(12'h040, 13'h1FFF);
    check("R10 flush after abort", 16'(fifo_flush), 16'h1);
    @(posedge clk); #1;
    check("R10 flush one cycle", 16'(fifo_flush), 16'h0);
    rd(8'h80, d); check("R8 defined cause bits", d, 16'h1EBF);
    rd(8'h54, d);
    rd(8'h80, d); check("R9 cause wiped", d, 16'h0);
    rd(8'h34, d); check("R9 abort bit cleared", d, 16'h0);
    fire(12'h040, 13'h0001);
    fire(12'h040, 13'h1000);
    rd(8'h80, d); check("R8 causes accumulate", d, 16'h1001);
    rd(8'h40, d);
    rd(8'h80, d); check("R6 clear all wipes cause", d, 16'h0);
    check("R10 flush idle", 16'(fifo_flush), 16'h0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    t_reset();
    t_latch();
    t_levels();
    t_mask();
    t_race();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule